// File: doc/BRIEF.md
# Serial Avionics Bus Word Receiver

The receiver takes a single Manchester II coded serial line that runs at 1 Mb/s and samples it with a clock sixteen times faster than the bit rate. It waits for the three-bit-time sync pulse. This pulse breaks the Manchester rule on purpose: one level is held for a bit and a half, then the opposite level for the same time. The order of those two levels gives the word type. The receiver then recovers the sixteen information bits and the parity bit from the cells that follow.

A word that passes every check is presented on a valid/ready output stream, together with a flag that gives its type. A word-received strobe pulses at the same time, so a processor can use it as an interrupt. A word that fails any check is discarded. The receiver then pulses a separate error strobe and ORs a cause code into a sticky status field, which the processor reads and then clears with a one-cycle pulse.

The output stream follows these back-pressure rules:
- `rx_valid` stays high, with its data stable, until `rx_ready` is seen high at a clock edge.
- No buffer stands behind the output register. A word that completes while the previous word is still waiting is dropped.

After any error the receiver looks only for a fresh, valid sync. The receive path is independent of any transmitter.

Top module: `serial_word_rx`

## Requirements
- R1: During and right after reset, `rx_valid`, `word_stb` and `err_stb` are 0 and `err_code` is 3'b000.
- R2: A sync first half is accepted only when the line holds one level for 20 to 28 sample clocks (1.5 bit times ±0.25 µs) and then changes. A level held for 19 or fewer samples, or for 29 or more, starts nothing: it raises no strobe and no error.
- R3: A sync that is high first marks a command/status word (`rx_is_cmd`=1). A sync that is low first marks a data word (`rx_is_cmd`=0).
- R4: Bit cells start 24 samples after the mid-sync transition and are 16 samples long. The two halves of a cell are sampled 4 and 12 samples into the cell. High-then-low decodes as 1 and low-then-high as 0. The first information bit received lands in `rx_data[15]`.
- R5: A cell whose two half samples are equal is a Manchester error. The word is discarded, `err_stb` pulses and bit 1 of `err_code` is set.
- R6: Parity is odd over the 16 information bits plus the parity bit. An even count discards the word, pulses `err_stb` and sets bit 2 of `err_code`.
- R7: After an accepted first half, the opposite level must last at least 20 samples. If the line changes earlier, `err_stb` pulses and bit 0 of `err_code` is set.
- R8: A good word sets `rx_valid` and pulses `word_stb` for one cycle. `rx_data` and `rx_is_cmd` stay stable while `rx_valid` is high and `rx_ready` is low. `rx_valid` drops after a handshake.
- R9: A word that completes while `rx_valid` is high and `rx_ready` is low is dropped. It raises no `word_stb`, and the held word is unchanged.
- R10: `err_code` bits accumulate by OR and hold until an `err_clr` pulse clears them. An error that arrives in the same cycle as the clear stays set.
- R11: After an error the receiver decodes nothing until a new valid sync arrives, and the next good word is then received normally.
- R12: A word may follow the previous word's parity cell with no gap. The next sync's first half is then timed from the end of that parity cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial Manchester line, asynchronous to clk |
| rx_ready | input | 1 | Consumer accepts the presented word |
| err_clr | input | 1 | One-cycle pulse that clears the error status |
| rx_valid | output | 1 | A decoded word is presented |
| rx_data | output | 16 | Decoded information bits, first received bit in bit 15 |
| rx_is_cmd | output | 1 | 1 for command/status sync, 0 for data sync |
| word_stb | output | 1 | One-cycle pulse when a good word is taken in |
| err_stb | output | 1 | One-cycle pulse when a word is rejected |
| err_code | output | 3 | Sticky cause: bit0 sync, bit1 Manchester, bit2 parity |

## Verification
Two situations are the hardest to reach from the ports. The first is a Manchester fault placed so that the corrupted cell does not itself form a run long enough to pass as a sync. The second is two words sent back to back, where the parity cell's tail merges with the next sync's first half.

The bench builds every waveform sample by sample through one word-driving task. That task can shorten or lengthen the sync, flip the parity, force one cell to a flat level chosen against its neighbours, and leave out the idle gap. With these controls both situations are produced on purpose, and the recovery that follows each of them is checked.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int WORD_W   = 16;
  localparam int ERR_W    = 3;
  localparam int ERR_SYNC = 0;
  localparam int ERR_MAN  = 1;
  localparam int ERR_PAR  = 2;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic              is_cmd;
    logic [WORD_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/swr_sync_in.sv
module swr_sync_in #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_LVL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_LVL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/swr_run_meter.sv
module swr_run_meter #(
  parameter int SYNC_MIN = 20,
  parameter int SYNC_MAX = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ln,
  input  logic restart,
  output logic sync_hit
);
  localparam int RUN_W = $clog2(SYNC_MAX + 1) + 1;

  logic             ln_q;
  logic [RUN_W-1:0] run_len;
  logic             edge_seen;

  assign edge_seen = (ln != ln_q);
  assign sync_hit  = edge_seen
                   && (run_len >= RUN_W'(SYNC_MIN))
                   && (run_len <= RUN_W'(SYNC_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q    <= 1'b0;
      run_len <= '1;
    end else begin
      ln_q <= ln;
      if (restart)             run_len <= '0;
      else if (edge_seen)      run_len <= RUN_W'(1);
      else if (run_len != '1)  run_len <= run_len + RUN_W'(1);
    end
  end
endmodule

// File: rtl/swr_frame.sv
module swr_frame
  import swr_pkg::*;
#(
  parameter int SPB       = 16,
  parameter int SYNC_NOM  = 24,
  parameter int SYNC2_MIN = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ln,
  input  logic             sync_hit,
  output logic             word_end,
  output logic             done_o,
  output rx_word_t         word_o,
  output logic [ERR_W-1:0] err_o
);
  localparam int HALF    = SPB / 2;
  localparam int S1_AT   = HALF / 2;
  localparam int S2_AT   = HALF + HALF / 2;
  localparam int CNT_MAX = (SYNC_NOM > SPB) ? SYNC_NOM : SPB;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int IDX_W   = $clog2(WORD_W + 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              s1;
  logic              exp_lvl;
  logic              is_cmd;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W:0]   shnext;
  logic              cell_end;

  assign shnext   = {shreg, s1};
  assign cell_end = (st == ST_BITS) && (cnt == CNT_W'(SPB - 1));
  assign word_end = cell_end && (idx == IDX_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      idx     <= '0;
      s1      <= 1'b0;
      exp_lvl <= 1'b0;
      is_cmd  <= 1'b0;
      shreg   <= '0;
      done_o  <= 1'b0;
      word_o  <= '0;
      err_o   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= '0;
      case (st)
        ST_HUNT: begin
          if (sync_hit) begin
            st      <= ST_SYNC2;
            cnt     <= CNT_W'(1);
            exp_lvl <= ln;
            is_cmd  <= ~ln;
          end
        end
        ST_SYNC2: begin
          if ((ln != exp_lvl) && (cnt < CNT_W'(SYNC2_MIN))) begin
            err_o[ERR_SYNC] <= 1'b1;
            st              <= ST_HUNT;
          end else if (cnt == CNT_W'(SYNC_NOM - 1)) begin
            st  <= ST_BITS;
            cnt <= '0;
            idx <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_BITS: begin
          if (cnt == CNT_W'(S1_AT)) s1 <= ln;
          if ((cnt == CNT_W'(S2_AT)) && (ln == s1)) begin
            err_o[ERR_MAN] <= 1'b1;
            st             <= ST_HUNT;
          end else if (cell_end) begin
            shreg <= shnext[WORD_W-1:0];
            cnt   <= '0;
            if (word_end) begin
              st <= ST_HUNT;
              if (^shnext) begin
                done_o        <= 1'b1;
                word_o.is_cmd <= is_cmd;
                word_o.data   <= shnext[WORD_W:1];
              end else begin
                err_o[ERR_PAR] <= 1'b1;
              end
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/swr_out.sv
module swr_out
  import swr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  rx_word_t          word_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              out_ready,
  input  logic              err_clr,
  output logic              out_valid,
  output rx_word_t          out_word,
  output logic              word_stb,
  output logic              err_stb,
  output logic [ERR_W-1:0]  err_code
);
  logic accept;

  assign accept = done_i && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      word_stb  <= 1'b0;
      err_stb   <= 1'b0;
      err_code  <= '0;
    end else begin
      word_stb <= accept;
      err_stb  <= |err_i;
      err_code <= (err_clr ? '0 : err_code) | err_i;
      if (accept) begin
        out_valid <= 1'b1;
        out_word  <= word_i;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import swr_pkg::*;
#(
  parameter int SPB       = 16,
  parameter int IN_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_ready,
  input  logic              err_clr,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_is_cmd,
  output logic              word_stb,
  output logic              err_stb,
  output logic [ERR_W-1:0]  err_code
);
  localparam int SYNC_NOM = 3 * SPB / 2;
  localparam int SYNC_TOL = SPB / 4;
  localparam int SYNC_MIN = SYNC_NOM - SYNC_TOL;
  localparam int SYNC_MAX = SYNC_NOM + SYNC_TOL;

  logic             ln;
  logic             sync_hit;
  logic             word_end;
  logic             done;
  rx_word_t         word;
  logic [ERR_W-1:0] err;
  rx_word_t         out_word;

  swr_sync_in #(.STAGES(IN_STAGES), .RST_LVL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(ln)
  );

  swr_run_meter #(.SYNC_MIN(SYNC_MIN), .SYNC_MAX(SYNC_MAX)) u_run (
    .clk(clk), .rst_n(rst_n), .ln(ln), .restart(word_end), .sync_hit(sync_hit)
  );

  swr_frame #(.SPB(SPB), .SYNC_NOM(SYNC_NOM), .SYNC2_MIN(SYNC_MIN)) u_frame (
    .clk(clk), .rst_n(rst_n), .ln(ln), .sync_hit(sync_hit),
    .word_end(word_end), .done_o(done), .word_o(word), .err_o(err)
  );

  swr_out u_out (
    .clk(clk), .rst_n(rst_n), .done_i(done), .word_i(word), .err_i(err),
    .out_ready(rx_ready), .err_clr(err_clr), .out_valid(rx_valid),
    .out_word(out_word), .word_stb(word_stb), .err_stb(err_stb),
    .err_code(err_code)
  );

  assign rx_data   = out_word.data;
  assign rx_is_cmd = out_word.is_cmd;
endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        err_clr,
  input logic        rx_valid,
  input logic [15:0] rx_data,
  input logic        rx_is_cmd,
  input logic        word_stb,
  input logic        err_stb,
  input logic [2:0]  err_code
);
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_is_cmd)); // R8
  AST_STB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> rx_valid); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> !word_stb); // R9
  AST_REJECT_NOT_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> !word_stb); // R5
  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_code & $past(err_code)) == $past(err_code))); // R10
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> (err_code != 3'b000)); // R10
endmodule

bind serial_word_rx serial_word_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .err_clr(err_clr),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_cmd(rx_is_cmd),
  .word_stb(word_stb), .err_stb(err_stb), .err_code(err_code)
);

// File: tb/tb_serial_word_rx.sv
module tb_serial_word_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {is_cmd, parity_flip, data}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'h0000}, {1'b0, 1'b0, 16'hFFFF},
    {1'b1, 1'b0, 16'hA5C3}, {1'b0, 1'b0, 16'h1234},
    {1'b1, 1'b1, 16'h8001}, {1'b0, 1'b0, 16'h7FFE},
    {1'b0, 1'b1, 16'h0F0F}, {1'b1, 1'b0, 16'h5555}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic        ready = 1'b0;
  logic        clr = 1'b0;
  logic        rx_valid, rx_is_cmd, word_stb, err_stb;
  logic [15:0] rx_data;
  logic [2:0]  err_code;

  int checks = 0;
  int fails = 0;
  int wcnt = 0;
  int ecnt = 0;
  logic [16:0] last_w = '0;
  logic [16:0] prev_w = '0;
  bit finished = 0;

  serial_word_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_line(line), .rx_ready(ready), .err_clr(clr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_cmd(rx_is_cmd),
    .word_stb(word_stb), .err_stb(err_stb), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (word_stb) begin
      wcnt <= wcnt + 1;
      prev_w <= last_w;
      last_w <= {rx_is_cmd, rx_data};
    end
    if (err_stb) ecnt <= ecnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line = lvl;
    end
  endtask

  task automatic send_word(input logic cmd, input logic [15:0] d, input int h1,
                           input logic pflip, input int bad_cell,
                           input logic pre, input logic gap);
    logic par;
    logic b;
    par = ~(^d) ^ pflip;
    if (pre) drive(~cmd, 40);
    drive(cmd, h1);
    drive(~cmd, 24);
    for (int c = 0; c < 17; c++) begin
      b = (c < 16) ? d[15-c] : par;
      if (c == bad_cell) begin
        drive(~b, 16);
      end else begin
        drive(b, 8);
        drive(~b, 8);
      end
    end
    if (gap) drive(1'b0, 40);
  endtask

  task automatic take();
    @(negedge clk) ready = 1'b1;
    @(negedge clk) ready = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w0, e0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", rx_valid, 0);
    chk("R1 code in reset", err_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {word_stb, err_stb}, 0);
    drive(1'b0, 40);

    // vector table: R3 R4 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      w0 = wcnt; e0 = ecnt;
      send_word(VEC[v][17], VEC[v][15:0], 24, VEC[v][16], -1, 1'b1, 1'b1);
      if (!VEC[v][16]) begin
        chk("R8 valid after good word", rx_valid, 1);
        chk("R4 data", rx_data, VEC[v][15:0]);
        chk("R3 type flag", rx_is_cmd, VEC[v][17]);
        chk("R8 one word strobe", wcnt - w0, 1);
        chk("R6 no error on good parity", err_code, 0);
        take();
        chk("R8 valid drops after handshake", rx_valid, 0);
      end else begin
        chk("R6 parity code", err_code, 3'b100);
        chk("R6 error strobe", ecnt - e0, 1);
        chk("R6 word discarded", {rx_valid, 16'(wcnt - w0)}, 0);
        clear_err();
      end
    end

    // R2 tolerance edges
    w0 = wcnt;
    send_word(1'b1, 16'h3C5A, 20, 1'b0, -1, 1'b1, 1'b1);
    chk("R2 first half 20 accepted", {16'(wcnt - w0), rx_data}, {16'd1, 16'h3C5A});
    take();
    w0 = wcnt;
    send_word(1'b0, 16'hC001, 28, 1'b0, -1, 1'b1, 1'b1);
    chk("R2 first half 28 accepted", {16'(wcnt - w0), rx_data}, {16'd1, 16'hC001});
    take();
    w0 = wcnt; e0 = ecnt;
    drive(1'b1, 19); drive(1'b0, 60);
    drive(1'b1, 29); drive(1'b0, 60);
    chk("R2 out-of-range sync ignored", {16'(wcnt - w0), 16'(ecnt - e0)}, 0);
    chk("R2 no error code", err_code, 0);

    // R7 sync second half too short
    e0 = ecnt;
    drive(1'b1, 24); drive(1'b0, 10); drive(1'b1, 10); drive(1'b0, 40);
    chk("R7 sync error code", err_code, 3'b001);
    chk("R7 error strobe", ecnt - e0, 1);
    clear_err();

    // R5 Manchester error in cell 1, then R11 resync
    w0 = wcnt; e0 = ecnt;
    send_word(1'b1, 16'h8000, 24, 1'b0, 1, 1'b1, 1'b1);
    chk("R5 manchester code", err_code, 3'b010);
    chk("R5 word discarded", {rx_valid, 16'(wcnt - w0), 16'(ecnt - e0)}, {1'b0, 16'd0, 16'd1});
    // R10 sticky accumulation
    send_word(1'b0, 16'h0001, 24, 1'b1, -1, 1'b1, 1'b1);
    chk("R10 codes accumulate", err_code, 3'b110);
    w0 = wcnt;
    send_word(1'b0, 16'h1357, 24, 1'b0, -1, 1'b1, 1'b1);
    chk("R11 resync word received", {16'(wcnt - w0), rx_data}, {16'd1, 16'h1357});
    chk("R10 code held until clear", err_code, 3'b110);
    take();
    clear_err();
    chk("R10 clear pulse empties code", err_code, 0);

    // R9 back-pressure
    w0 = wcnt;
    send_word(1'b1, 16'h1111, 24, 1'b0, -1, 1'b1, 1'b1);
    send_word(1'b0, 16'h2222, 24, 1'b0, -1, 1'b1, 1'b1);
    chk("R9 second word dropped", wcnt - w0, 1);
    chk("R9 held word unchanged", {rx_valid, rx_is_cmd, rx_data}, {1'b1, 1'b1, 16'h1111});
    take();
    chk("R9 valid drops after take", rx_valid, 0);

    // R12 back-to-back words
    ready = 1'b1;
    w0 = wcnt;
    send_word(1'b1, 16'hC3C3, 24, 1'b0, -1, 1'b1, 1'b0);
    send_word(1'b0, 16'h0F0F, 24, 1'b0, -1, 1'b0, 1'b1);
    chk("R12 both words received", wcnt - w0, 2);
    chk("R12 first word", prev_w, {1'b1, 16'hC3C3});
    chk("R12 second word", last_w, {1'b0, 16'h0F0F});
    chk("R12 no error", err_code, 0);
    ready = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule